// File: doc/BRIEF.md
# Raster Timing Generator with Pixel-Rate Divider

This block paces a parallel RGB display panel. A programmable integer divider turns a fast video clock into a pixel-rate enable. Two cascaded position counters then walk every line and every frame. From those counters the block drives active-low horizontal and vertical sync, a data-enable strobe, and the column and row of the current pixel inside the visible area.

Every timing field arrives on plain input ports, written as its true length minus one. The porches, the sync widths, the visible width and height, and the divider all use this form. A global enable starts the raster. Dropping the enable stops the raster only once the current frame has finished. A pending frame interrupt is raised either at the start of vertical sync or at the start of the vertical front porch, and software clears it by pulsing a clear input. A one-cycle pulse marks the start of one chosen visible line. A synchronous soft reset returns everything to idle.

Top module: `vtg_core`

## Requirements
- R1: After `rst_n` low, or in the cycle after `soft_rst` is high, the block is idle. Idle means `hsync_n`=1, `vsync_n`=1, `de`=0, `x_pos`=0, `y_pos`=0, `frame_irq`=0 and `line_hit`=0, and this holds until the enable starts a frame.
- R2: A line is `h_sync_m1+1` sync pixels, then `h_back_m1+1` back-porch pixels, then `h_act_m1+1` visible pixels, then `h_front_m1+1` front-porch pixels. `hsync_n` is 0 exactly during the sync pixels.
- R3: A frame follows the same order counted in lines, using the `v_*_m1` fields. `vsync_n` is 0 exactly during the sync lines, and it falls at the first pixel of a line.
- R4: `de` is 1 only when the pixel is both in the visible part of the line and in a visible line. `x_pos` is the pixel's index within the visible part of the line, or 0 outside it. `y_pos` is the line's index among the visible lines, or 0 outside them.
- R5: Each pixel lasts `div_m1+1` clock cycles. `div_m1`=0 is the bypass, at one pixel per clock. `div_m1`=255 gives 256 clocks per pixel.
- R6: When `enable` is sampled high while idle, the first pixel of the frame (line 0, pixel 0) is presented in the next cycle.
- R7: When `enable` drops mid-frame, the frame runs to its last pixel and the block then goes idle.
- R8: `frame_irq` is a pending flag. It is set when `irq_en`=1 and a selected event occurs. With `irq_sel`=1 the event is the first cycle of vertical sync, including the first frame after the start. With `irq_sel`=0 the event is the first cycle of the first front-porch line. With `irq_en`=0 the flag is never set.
- R9: A one-cycle `irq_clr` pulse clears `frame_irq` in the following cycle. If a set event and a clear fall on the same edge, the set wins.
- R10: `line_hit` is high for exactly one clock, in the first cycle of visible line number `line_thr` (0-based). The intended setting is `line_thr` = `v_act_m1`, which marks the last visible line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Video clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Synchronous return to idle |
| enable | input | 1 | Start of the raster; a drop takes effect at frame end |
| div_m1 | input | DIV_W | Clocks per pixel minus one |
| h_sync_m1 | input | HW | Horizontal sync width minus one |
| h_back_m1 | input | HW | Horizontal back porch minus one |
| h_act_m1 | input | HW | Visible width minus one |
| h_front_m1 | input | HW | Horizontal front porch minus one |
| v_sync_m1 | input | VW | Vertical sync lines minus one |
| v_back_m1 | input | VW | Vertical back porch lines minus one |
| v_act_m1 | input | VW | Visible lines minus one |
| v_front_m1 | input | VW | Vertical front porch lines minus one |
| line_thr | input | VW | Visible line index that fires line_hit |
| irq_en | input | 1 | Allows the frame flag to be set |
| irq_sel | input | 1 | 1: vertical sync start, 0: front porch start |
| irq_clr | input | 1 | Clear pulse for frame_irq |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| de | output | 1 | Visible pixel strobe |
| x_pos | output | HW | Visible column |
| y_pos | output | VW | Visible row |
| frame_irq | output | 1 | Pending frame flag |
| line_hit | output | 1 | One-clock line marker |

## Verification
Every output is registered at the same edge that advances the counters, so any change is first visible in the cycle after the pixel-enable edge. The bench counts cycles from the edge that samples `enable`, and cycle k shows pixel (k-1)/(div_m1+1). The frame flag and the line marker appear in the first cycle of the line they mark, and a clear pulse takes effect one cycle after it is driven. The bench drives and samples on the falling edge, and it derives every expected value from that cycle count. A table of timing sets runs two whole frames each. Directed runs then cover reset, the frame-end stop, soft reset, both interrupt events, set-over-clear priority, the largest divider and a threshold of zero.

// File: rtl/vtg_pkg.sv
package vtg_pkg;
  // Frame-flag event choice, driven on irq_sel.
  typedef enum logic {
    EVT_FRONT = 1'b0,
    EVT_VSYNC = 1'b1
  } vtg_evt_e;
endpackage

// File: rtl/vtg_pixdiv.sv
// Pixel-rate enable: one pulse every div_m1+1 clocks while running.
module vtg_pixdiv #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             run,
  input  logic [DIV_W-1:0] div_m1,
  output logic             pix_ce
);
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             at_top;

  assign at_top = (cnt_q == div_m1);
  assign pix_ce = run & at_top;

  always_comb begin
    cnt_d = cnt_q;
    if (clr || !run)  cnt_d = '0;
    else if (at_top)  cnt_d = '0;
    else              cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/vtg_axis.sv
// One raster axis: position counter over sync, back porch, visible, front porch.
module vtg_axis #(
  parameter int CW = 12,
  localparam int TW = CW + 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          step,
  input  logic [CW-1:0] sync_m1,
  input  logic [CW-1:0] back_m1,
  input  logic [CW-1:0] act_m1,
  input  logic [CW-1:0] front_m1,
  output logic [TW-1:0] cnt,
  output logic [TW-1:0] cnt_nxt,
  output logic [TW-1:0] act_beg,
  output logic [TW-1:0] act_end,
  output logic          last
);
  logic [TW-1:0] cnt_q, cnt_d, total_m1;

  assign act_beg  = TW'(sync_m1) + TW'(back_m1) + TW'(2);
  assign act_end  = act_beg + TW'(act_m1) + TW'(1);
  assign total_m1 = act_end + TW'(front_m1);
  assign last     = (cnt_q == total_m1);

  always_comb begin
    cnt_d = cnt_q;
    if (clr)       cnt_d = '0;
    else if (step) cnt_d = last ? '0 : cnt_q + 1'b1;
  end

  assign cnt     = cnt_q;
  assign cnt_nxt = cnt_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/vtg_core.sv
module vtg_core
  import vtg_pkg::*;
#(
  parameter int HW    = 12,
  parameter int VW    = 12,
  parameter int DIV_W = 8,
  localparam int HTW  = HW + 2,
  localparam int VTW  = VW + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_rst,
  input  logic             enable,
  input  logic [DIV_W-1:0] div_m1,
  input  logic [HW-1:0]    h_sync_m1,
  input  logic [HW-1:0]    h_back_m1,
  input  logic [HW-1:0]    h_act_m1,
  input  logic [HW-1:0]    h_front_m1,
  input  logic [VW-1:0]    v_sync_m1,
  input  logic [VW-1:0]    v_back_m1,
  input  logic [VW-1:0]    v_act_m1,
  input  logic [VW-1:0]    v_front_m1,
  input  logic [VW-1:0]    line_thr,
  input  logic             irq_en,
  input  logic             irq_sel,
  input  logic             irq_clr,
  output logic             hsync_n,
  output logic             vsync_n,
  output logic             de,
  output logic [HW-1:0]    x_pos,
  output logic [VW-1:0]    y_pos,
  output logic             frame_irq,
  output logic             line_hit
);
  logic           run_q, run_d;
  logic           pix_ce;
  logic           axis_clr, v_step;
  logic [HTW-1:0] h_cnt, h_nxt, h_beg, h_end;
  logic [VTW-1:0] v_cnt, v_nxt, v_beg, v_end;
  logic           h_last, v_last;
  logic           start_evt, wrap_evt, front_evt, mark_evt, sel_evt;
  logic           pend_q, pend_d, hit_q, hit_d;
  logic           h_in_act, v_in_act;
  vtg_evt_e       evt_sel;

  vtg_pixdiv #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n), .clr(soft_rst), .run(run_q),
    .div_m1(div_m1), .pix_ce(pix_ce)
  );

  assign axis_clr = soft_rst | ~run_q;
  assign v_step   = pix_ce & h_last;

  vtg_axis #(.CW(HW)) u_hax (
    .clk(clk), .rst_n(rst_n), .clr(axis_clr), .step(pix_ce),
    .sync_m1(h_sync_m1), .back_m1(h_back_m1), .act_m1(h_act_m1), .front_m1(h_front_m1),
    .cnt(h_cnt), .cnt_nxt(h_nxt), .act_beg(h_beg), .act_end(h_end), .last(h_last)
  );

  vtg_axis #(.CW(VW)) u_vax (
    .clk(clk), .rst_n(rst_n), .clr(axis_clr), .step(v_step),
    .sync_m1(v_sync_m1), .back_m1(v_back_m1), .act_m1(v_act_m1), .front_m1(v_front_m1),
    .cnt(v_cnt), .cnt_nxt(v_nxt), .act_beg(v_beg), .act_end(v_end), .last(v_last)
  );

  // Run control: start from idle at once, stop only on the frame's last pixel.
  always_comb begin
    run_d = run_q;
    if (soft_rst)                                    run_d = 1'b0;
    else if (!run_q && enable)                       run_d = 1'b1;
    else if (run_q && v_step && v_last && !enable)   run_d = 1'b0;
  end

  // Events, each aligned with the edge that enters the marked position.
  assign start_evt = ~soft_rst & ~run_q & enable;
  assign wrap_evt  = ~soft_rst & v_step & v_last & enable;
  assign front_evt = ~soft_rst & v_step & (h_nxt == '0) & (v_nxt == v_end);
  assign mark_evt  = ~soft_rst & v_step & (h_nxt == '0) & (v_nxt == v_beg + VTW'(line_thr));
  assign evt_sel   = vtg_evt_e'(irq_sel);
  assign sel_evt   = (evt_sel == EVT_VSYNC) ? (start_evt | wrap_evt) : front_evt;

  always_comb begin
    pend_d = pend_q;
    if (soft_rst)              pend_d = 1'b0;
    else if (irq_en && sel_evt) pend_d = 1'b1;
    else if (irq_clr)          pend_d = 1'b0;
  end

  assign hit_d = mark_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      pend_q <= 1'b0;
      hit_q  <= 1'b0;
    end else begin
      run_q  <= run_d;
      pend_q <= pend_d;
      hit_q  <= hit_d;
    end
  end

  // Decode of the registered positions.
  assign h_in_act = (h_cnt >= h_beg) && (h_cnt < h_end);
  assign v_in_act = (v_cnt >= v_beg) && (v_cnt < v_end);

  assign hsync_n   = ~(run_q && (h_cnt <= HTW'(h_sync_m1)));
  assign vsync_n   = ~(run_q && (v_cnt <= VTW'(v_sync_m1)));
  assign de        = run_q & h_in_act & v_in_act;
  assign x_pos     = h_in_act ? HW'(h_cnt - h_beg) : '0;
  assign y_pos     = v_in_act ? VW'(v_cnt - v_beg) : '0;
  assign frame_irq = pend_q;
  assign line_hit  = hit_q;
endmodule

// File: rtl/vtg_core_chk.sv
module vtg_core_chk (
  input logic clk,
  input logic rst_n,
  input logic soft_rst,
  input logic run_q,
  input logic pix_ce,
  input logic irq_en,
  input logic hsync_n,
  input logic vsync_n,
  input logic de,
  input logic frame_irq,
  input logic line_hit
);
  a_r1_soft_idle: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (hsync_n && vsync_n && !de && !frame_irq && !line_hit));

  a_r3_vsync_at_line_start: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(vsync_n) |-> !hsync_n);

  a_r4_de_outside_sync: assert property (@(posedge clk) disable iff (!rst_n)
    de |-> (hsync_n && vsync_n));

  a_r5_hold_between_pixels: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !pix_ce && !soft_rst) |=> ($stable(hsync_n) && $stable(vsync_n) && $stable(de)));

  a_r8_set_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frame_irq) |-> $past(irq_en));

  a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    line_hit |=> !line_hit);
endmodule

bind vtg_core vtg_core_chk u_chk (
  .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .run_q(run_q), .pix_ce(pix_ce),
  .irq_en(irq_en), .hsync_n(hsync_n), .vsync_n(vsync_n), .de(de),
  .frame_irq(frame_irq), .line_hit(line_hit)
);

// File: tb/vtg_core_tb.sv
`timescale 1ns/1ps
module vtg_core_tb;
  logic        clk = 1'b0;
  logic        rst_n, soft_rst, enable, irq_en, irq_sel, irq_clr;
  logic [7:0]  div_m1;
  logic [11:0] h_sync_m1, h_back_m1, h_act_m1, h_front_m1;
  logic [11:0] v_sync_m1, v_back_m1, v_act_m1, v_front_m1, line_thr;
  logic        hsync_n, vsync_n, de, frame_irq, line_hit;
  logic [11:0] x_pos, y_pos;

  int errs = 0;
  int chks = 0;
  int k = 0;
  bit done = 0;

  // Fields: h sync,back,act,front; v sync,back,act,front (all minus one); div_m1; clocks per frame.
  localparam int TBL [3][10] = '{
    '{1, 2, 3, 1, 0, 1, 2, 0, 0, 77},
    '{0, 0, 2, 0, 1, 0, 1, 1, 2, 126},
    '{2, 1, 4, 3, 0, 0, 0, 0, 1, 112}
  };

  always #2.5 clk = ~clk;

  vtg_core u_dut (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .enable(enable), .div_m1(div_m1),
    .h_sync_m1(h_sync_m1), .h_back_m1(h_back_m1), .h_act_m1(h_act_m1), .h_front_m1(h_front_m1),
    .v_sync_m1(v_sync_m1), .v_back_m1(v_back_m1), .v_act_m1(v_act_m1), .v_front_m1(v_front_m1),
    .line_thr(line_thr), .irq_en(irq_en), .irq_sel(irq_sel), .irq_clr(irq_clr),
    .hsync_n(hsync_n), .vsync_n(vsync_n), .de(de), .x_pos(x_pos), .y_pos(y_pos),
    .frame_irq(frame_irq), .line_hit(line_hit)
  );

  task automatic chk(input string req, input int act, input int exp);
    chks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s at k=%0d: actual=%0d expected=%0d", req, k, act, exp);
    end
  endtask

  task automatic apply(input int i);
    h_sync_m1 = 12'(TBL[i][0]); h_back_m1 = 12'(TBL[i][1]);
    h_act_m1  = 12'(TBL[i][2]); h_front_m1 = 12'(TBL[i][3]);
    v_sync_m1 = 12'(TBL[i][4]); v_back_m1 = 12'(TBL[i][5]);
    v_act_m1  = 12'(TBL[i][6]); v_front_m1 = 12'(TBL[i][7]);
    div_m1    = 8'(TBL[i][8]);
    line_thr  = 12'(TBL[i][6]);
  endtask

  task automatic idle_all();
    @(negedge clk);
    soft_rst = 1'b1; enable = 1'b0; irq_clr = 1'b0;
    @(negedge clk);
    soft_rst = 1'b0;
  endtask

  // Enable sampled at edge E; returns at the falling edge of cycle k=1.
  task automatic go();
    @(negedge clk);
    enable = 1'b1;
    @(posedge clk);
    @(negedge clk);
    k = 1;
  endtask

  task automatic upto(input int t);
    while (k < t) begin
      @(negedge clk);
      k++;
    end
  endtask

  task automatic chk_idle(input string req);
    chk(req, int'(hsync_n), 1);
    chk(req, int'(vsync_n), 1);
    chk(req, int'(de), 0);
    chk(req, int'(x_pos), 0);
    chk(req, int'(y_pos), 0);
    chk(req, int'(frame_irq), 0);
    chk(req, int'(line_hit), 0);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      chks++; errs++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, chks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; soft_rst = 1'b0; enable = 1'b0;
    irq_en = 1'b1; irq_sel = 1'b1; irq_clr = 1'b0;
    apply(0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk_idle("R1 reset");

    // Table walk: two frames per timing set, every output every cycle.
    for (int i = 0; i < 3; i++) begin
      int hs, hb, ha, hf, vs, vb, va, vf, d, ht, vt, fr;
      apply(i);
      hs = TBL[i][0] + 1; hb = TBL[i][1] + 1; ha = TBL[i][2] + 1; hf = TBL[i][3] + 1;
      vs = TBL[i][4] + 1; vb = TBL[i][5] + 1; va = TBL[i][6] + 1; vf = TBL[i][7] + 1;
      d  = TBL[i][8] + 1; fr = TBL[i][9];
      ht = hs + hb + ha + hf; vt = vs + vb + va + vf;
      idle_all();
      go();
      while (k <= 2 * fr) begin
        int p, h, v, hact, vact;
        p = (k - 1) / d;
        h = p % ht;
        v = (p / ht) % vt;
        hact = (h >= hs + hb && h < hs + hb + ha) ? 1 : 0;
        vact = (v >= vs + vb && v < vs + vb + va) ? 1 : 0;
        chk("R2 R5 R6 hsync", int'(hsync_n), (h < hs) ? 0 : 1);
        chk("R3 vsync", int'(vsync_n), (v < vs) ? 0 : 1);
        chk("R4 de", int'(de), hact & vact);
        chk("R4 x_pos", int'(x_pos), hact ? h - hs - hb : 0);
        chk("R4 y_pos", int'(y_pos), vact ? v - vs - vb : 0);
        chk("R8 R9 frame_irq", int'(frame_irq), ((k - 1) % fr == 0) ? 1 : 0);
        chk("R10 line_hit", int'(line_hit),
            (h == 0 && v == vs + vb + va - 1 && (k - 1) % d == 0) ? 1 : 0);
        irq_clr = ((k - 1) % fr == 0) ? 1'b1 : 1'b0;
        @(negedge clk);
        k++;
      end
      irq_clr = 1'b0;
    end

    // R7: enable dropped mid-frame, frame completes, then idle.
    apply(0);
    idle_all();
    go();
    upto(30); enable = 1'b0;
    upto(40); chk("R7 still running", int'(de), 1);
    upto(77); chk("R7 last pixel", int'(vsync_n), 1);
    upto(78); chk("R7 idle after frame", int'(vsync_n), 1);
    chk("R7 idle after frame", int'(hsync_n), 1);
    upto(79); chk("R7 stays idle", int'(hsync_n), 1);

    // R1: soft reset mid-frame.
    idle_all();
    go();
    upto(40); chk("R8 pending before soft reset", int'(frame_irq), 1);
    soft_rst = 1'b1; enable = 1'b0;
    upto(41); chk_idle("R1 soft reset");
    soft_rst = 1'b0;

    // R8: front porch event.
    irq_sel = 1'b0;
    idle_all();
    go();
    chk("R8 no set at vsync when front selected", int'(frame_irq), 0);
    upto(66); chk("R8 before front porch", int'(frame_irq), 0);
    upto(67); chk("R8 front porch set", int'(frame_irq), 1);
    irq_sel = 1'b1;

    // R8: disabled flag never set.
    irq_en = 1'b0;
    idle_all();
    go();
    chk("R8 disabled at start", int'(frame_irq), 0);
    upto(78); chk("R8 disabled next frame", int'(frame_irq), 0);
    irq_en = 1'b1;

    // R9: clear works, and set beats clear on the same edge.
    idle_all();
    go();
    irq_clr = 1'b1;
    upto(2); irq_clr = 1'b0;
    chk("R9 cleared", int'(frame_irq), 0);
    upto(77); irq_clr = 1'b1;
    upto(78); irq_clr = 1'b0;
    chk("R9 set wins over clear", int'(frame_irq), 1);

    // R10: threshold at the first visible line (line 3 of config 0).
    line_thr = 12'd0;
    idle_all();
    go();
    upto(33); chk("R10 before mark", int'(line_hit), 0);
    upto(34); chk("R10 mark", int'(line_hit), 1);
    upto(35); chk("R10 one clock", int'(line_hit), 0);

    // R5: largest divider, one sync pixel.
    h_sync_m1 = 12'd0; div_m1 = 8'd255;
    idle_all();
    go();
    chk("R5 first pixel sync", int'(hsync_n), 0);
    upto(256); chk("R5 pixel held 256 clocks", int'(hsync_n), 0);
    upto(257); chk("R5 next pixel", int'(hsync_n), 1);
    idle_all();

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, chks);
    $finish;
  end
endmodule